// File: doc/BRIEF.md
# Multi-Subnet Classification Sequencer

This controller runs the subnets of a neuron array one after another and collects one classification result per subnet. Each subnet has a feature vector of its own length. The sequencer emits a read strobe per subnet with an element index, so that feature storage can be addressed. It emits a load strobe one cycle later so the neurons can take the fetched element. After the last load of a subnet it holds that subnet's output strobe while the registered inter-neuron bus settles. In the cycle after that window it samples the winning distance and category from the bus into the subnet's result slot.

The read stream does not stop between subnets. The first element of subnet j+1 is read in the cycle after the last element of subnet j. The loading of the next subnet therefore hides the settling wait of the previous one. A run is started by a one-cycle start pulse. A single-cycle done pulse marks the cycle in which the last result becomes visible. The run length depends only on the parameters and never on the bus values.

For the overlap to stay free of conflicts, every subnet after the first must have a vector length of at least NR+2. The first subnet may be of any length of one or more.

Top module: `rbf_subnet_sequencer`

## Requirements
- R1: Cycle 0 is the first cycle after the clock edge that accepts start. Subnet j has `re[j]` high for exactly D_j consecutive cycles, starting in cycle C_j = D_0+...+D_(j-1), with `rd_pos` counting 0 to D_j-1 over that window. No read is issued after the last subnet's window.
- R2: `le` equals `re` delayed by one clock, for every bit.
- R3: With R_j = C_j+D_j-1 as the cycle of subnet j's last read, `oe[j]` is high in cycles R_j+2 to R_j+NR+2 (NR+1 cycles) and low otherwise.
- R4: Slot j of `res_dst` / `res_cat` takes the `bus_dst` / `bus_cat` value that is present in cycle R_j+NR+3. The new value is visible from cycle R_j+NR+4 and is held until the next capture for that slot; other slots are unchanged.
- R5: `done` is high for exactly one cycle, cycle S+NR+3 with S = D_0+...+D_(NSUB-1), for any bus contents.
- R6: A start pulse that arrives while a run is in progress has no effect on the enables, the results or the timing of done.
- R7: While reset is high and in the first cycle after it, all enables and `done` are low and every result slot is zero.
- R8: At most one bit of `re` and at most one bit of `oe` are high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run at subnet 0; ignored while busy |
| bus_dst | input | DSTW | Smallest distance on the neuron chain output |
| bus_cat | input | CATW | Category belonging to that distance |
| re | output | NSUB | Per-subnet feature read strobe |
| le | output | NSUB | Per-subnet neuron load strobe |
| oe | output | NSUB | Per-subnet output strobe held during settling |
| rd_pos | output | DW | Element index of the current read |
| res_dst | output | NSUB*DSTW | Captured distances, slot j at bits j*DSTW |
| res_cat | output | NSUB*CATW | Captured categories, slot j at bits j*CATW |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the block with three subnets, NR of 2 and vector lengths 2, 4 and 6. The first subnet is shorter than the settling window. The later two include the shortest legal length, so subnet 0's capture falls in the cycle just before subnet 1's output strobe rises. The bus carries a value that changes every cycle, so a capture taken one cycle early or late lands on a wrong value. A second start pulse in the middle of a run tests that the block ignores it.

// File: rtl/rbfseq_pkg.sv
`timescale 1ns/1ps
package rbfseq_pkg;
    localparam int SUB_BITS = 8;
    localparam int CNT_BITS = 8;

    typedef enum logic {RD_IDLE, RD_RUN} rd_state_t;

    typedef struct packed {
        logic                act;
        logic [SUB_BITS-1:0] sub;
        logic [CNT_BITS-1:0] cnt;
    } settle_t;

    function automatic logic [SUB_BITS-1:0] first_set(input logic [255:0] v);
        logic [SUB_BITS-1:0] r;
        r = '0;
        for (int i = 255; i >= 0; i--) begin
            if (v[i]) r = SUB_BITS'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/rbfseq_reader.sv
`timescale 1ns/1ps
module rbfseq_reader
    import rbfseq_pkg::*;
#(
    parameter int NSUB = 3,
    parameter int DW = 8,
    parameter logic [NSUB*DW-1:0] DIM_LIST = {8'd6, 8'd5, 8'd4}
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    output logic [NSUB-1:0] re,
    output logic [DW-1:0]   rd_pos,
    output logic            rd_last,
    output logic            reading
);
    rd_state_t           state;
    logic [SUB_BITS-1:0] sub;
    logic [DW-1:0]       pos;
    logic [DW-1:0]       cur_dim;
    logic                end_of_vec;

    assign cur_dim    = DIM_LIST[int'(sub)*DW +: DW];
    assign end_of_vec = (pos == cur_dim - DW'(1));
    assign reading    = (state == RD_RUN);
    assign rd_last    = reading && end_of_vec;
    assign rd_pos     = pos;
    assign re         = reading ? (NSUB'(1) << sub) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RD_IDLE;
            sub   <= '0;
            pos   <= '0;
        end else begin
            case (state)
                RD_IDLE: begin
                    if (go) begin
                        state <= RD_RUN;
                        sub   <= '0;
                        pos   <= '0;
                    end
                end
                default: begin
                    if (end_of_vec) begin
                        pos <= '0;
                        if (sub == SUB_BITS'(NSUB - 1)) begin
                            state <= RD_IDLE;
                            sub   <= '0;
                        end else begin
                            sub <= sub + SUB_BITS'(1);
                        end
                    end else begin
                        pos <= pos + DW'(1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/rbfseq_settle.sv
`timescale 1ns/1ps
module rbfseq_settle
    import rbfseq_pkg::*;
#(
    parameter int NSUB = 3,
    parameter int NR = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NSUB-1:0]     re,
    input  logic                rd_last,
    output logic [NSUB-1:0]     le,
    output logic [NSUB-1:0]     oe,
    output logic                cap_en,
    output logic [SUB_BITS-1:0] cap_sub,
    output logic                busy
);
    logic [NSUB-1:0]     le_q;
    logic                le_last_q;
    settle_t             st;
    logic                cap_q;
    logic [SUB_BITS-1:0] cap_sub_q;
    logic                window_end;

    assign window_end = st.act && (st.cnt == CNT_BITS'(NR));

    always_ff @(posedge clk) begin
        if (rst) begin
            le_q      <= '0;
            le_last_q <= 1'b0;
            st        <= '0;
            cap_q     <= 1'b0;
            cap_sub_q <= '0;
        end else begin
            le_q      <= re;
            le_last_q <= rd_last;
            cap_q     <= window_end;
            if (window_end) cap_sub_q <= st.sub;
            if (le_last_q) begin
                st.act <= 1'b1;
                st.sub <= first_set(256'(le_q));
                st.cnt <= '0;
            end else if (st.act) begin
                if (window_end) st.act <= 1'b0;
                else            st.cnt <= st.cnt + CNT_BITS'(1);
            end
        end
    end

    assign le      = le_q;
    assign oe      = st.act ? (NSUB'(1) << st.sub) : '0;
    assign cap_en  = cap_q;
    assign cap_sub = cap_sub_q;
    assign busy    = (le_q != '0) || st.act || cap_q;
endmodule

// File: rtl/rbfseq_capture.sv
`timescale 1ns/1ps
module rbfseq_capture
    import rbfseq_pkg::*;
#(
    parameter int NSUB = 3,
    parameter int DSTW = 12,
    parameter int CATW = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cap_en,
    input  logic [SUB_BITS-1:0]  cap_sub,
    input  logic [DSTW-1:0]      bus_dst,
    input  logic [CATW-1:0]      bus_cat,
    output logic [NSUB*DSTW-1:0] res_dst,
    output logic [NSUB*CATW-1:0] res_cat,
    output logic                 done
);
    for (genvar j = 0; j < NSUB; j++) begin : g_slot
        logic [DSTW-1:0] dst_q;
        logic [CATW-1:0] cat_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                dst_q <= '0;
                cat_q <= '0;
            end else if (cap_en && (cap_sub == SUB_BITS'(j))) begin
                dst_q <= bus_dst;
                cat_q <= bus_cat;
            end
        end
        assign res_dst[j*DSTW +: DSTW] = dst_q;
        assign res_cat[j*CATW +: CATW] = cat_q;
    end

    always_ff @(posedge clk) begin
        if (rst) done <= 1'b0;
        else     done <= cap_en && (cap_sub == SUB_BITS'(NSUB - 1));
    end
endmodule

// File: rtl/rbf_subnet_sequencer.sv
`timescale 1ns/1ps
module rbf_subnet_sequencer
    import rbfseq_pkg::*;
#(
    parameter int NSUB = 3,
    parameter int NR = 2,
    parameter int DW = 8,
    parameter logic [NSUB*DW-1:0] DIM_LIST = {8'd6, 8'd5, 8'd4},
    parameter int DSTW = 12,
    parameter int CATW = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [DSTW-1:0]      bus_dst,
    input  logic [CATW-1:0]      bus_cat,
    output logic [NSUB-1:0]      re,
    output logic [NSUB-1:0]      le,
    output logic [NSUB-1:0]      oe,
    output logic [DW-1:0]        rd_pos,
    output logic [NSUB*DSTW-1:0] res_dst,
    output logic [NSUB*CATW-1:0] res_cat,
    output logic                 done
);
    logic                rd_last;
    logic                reading;
    logic                settle_busy;
    logic                cap_en;
    logic [SUB_BITS-1:0] cap_sub;
    logic                go;

    assign go = start && !reading && !settle_busy;

    rbfseq_reader #(.NSUB(NSUB), .DW(DW), .DIM_LIST(DIM_LIST)) u_reader (
        .clk(clk), .rst(rst), .go(go), .re(re), .rd_pos(rd_pos),
        .rd_last(rd_last), .reading(reading)
    );

    rbfseq_settle #(.NSUB(NSUB), .NR(NR)) u_settle (
        .clk(clk), .rst(rst), .re(re), .rd_last(rd_last), .le(le), .oe(oe),
        .cap_en(cap_en), .cap_sub(cap_sub), .busy(settle_busy)
    );

    rbfseq_capture #(.NSUB(NSUB), .DSTW(DSTW), .CATW(CATW)) u_capture (
        .clk(clk), .rst(rst), .cap_en(cap_en), .cap_sub(cap_sub),
        .bus_dst(bus_dst), .bus_cat(bus_cat),
        .res_dst(res_dst), .res_cat(res_cat), .done(done)
    );
endmodule

// File: rtl/rbf_subnet_sequencer_chk.sv
`timescale 1ns/1ps
module rbf_subnet_sequencer_chk #(
    parameter int NSUB = 3,
    parameter int DSTW = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NSUB-1:0]      re,
    input logic [NSUB-1:0]      le,
    input logic [NSUB-1:0]      oe,
    input logic [NSUB*DSTW-1:0] res_dst,
    input logic                 done
);
    assert_le_follows_re_R2: assert property (@(posedge clk) disable iff (rst)
        le == $past(re));

    assert_single_read_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(re));

    assert_single_output_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(oe));

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    for (genvar j = 0; j < NSUB; j++) begin : g_chk
        assert_oe_after_load_R3: assert property (@(posedge clk) disable iff (rst)
            $fell(le[j]) |-> oe[j]);

        assert_capture_after_window_R4: assert property (@(posedge clk) disable iff (rst)
            !$stable(res_dst[j*DSTW +: DSTW]) |-> $past(oe[j], 2));

        if (j < NSUB - 1) begin : g_next
            assert_read_chain_R1: assert property (@(posedge clk) disable iff (rst)
                $fell(re[j]) |-> re[j+1]);
        end
    end
endmodule

bind rbf_subnet_sequencer rbf_subnet_sequencer_chk #(.NSUB(NSUB), .DSTW(DSTW)) u_chk (
    .clk(clk), .rst(rst), .re(re), .le(le), .oe(oe), .res_dst(res_dst), .done(done)
);

// File: tb/rbf_subnet_sequencer_bench.sv
`timescale 1ns/1ps
module rbf_subnet_sequencer_bench;
    localparam int NSUB = 3;
    localparam int NR = 2;
    localparam int DW = 8;
    localparam int DSTW = 12;
    localparam int CATW = 4;
    localparam logic [NSUB*DW-1:0] DIMS = {8'd6, 8'd4, 8'd2};
    localparam int D [NSUB] = '{2, 4, 6};

    typedef struct {
        logic [NSUB-1:0]      re, le, oe;
        logic [DW-1:0]        pos;
        logic                 done;
        bit                   chk_res;
        logic [NSUB*DSTW-1:0] rdst;
        logic [NSUB*CATW-1:0] rcat;
        int                   cyc;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [DSTW-1:0] bus_dst = '0;
    logic [CATW-1:0] bus_cat = '0;
    logic [NSUB-1:0] re, le, oe;
    logic [DW-1:0] rd_pos;
    logic [NSUB*DSTW-1:0] res_dst;
    logic [NSUB*CATW-1:0] res_cat;
    logic done;

    int vectors = 0;
    int errors = 0;
    bit finished = 1'b0;
    item_t exp_q[$];

    always #5 clk = ~clk;

    rbf_subnet_sequencer #(.NSUB(NSUB), .NR(NR), .DW(DW), .DIM_LIST(DIMS),
                           .DSTW(DSTW), .CATW(CATW)) u_rbf_subnet_sequencer (
        .clk(clk), .rst(rst), .start(start), .bus_dst(bus_dst), .bus_cat(bus_cat),
        .re(re), .le(le), .oe(oe), .rd_pos(rd_pos),
        .res_dst(res_dst), .res_cat(res_cat), .done(done)
    );

    task automatic chk(string tag, int cyc, logic [63:0] act, logic [63:0] expv);
        vectors++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, expv);
        end
    endtask

    // Driver: computes the schedule from the requirements and queues it.
    task automatic run_seq(int base, int cat_off, int extra_start);
        int c0 [NSUB];
        int rl [NSUB];
        int s;
        int t_done;
        logic [NSUB*DSTW-1:0] fdst;
        logic [NSUB*CATW-1:0] fcat;
        s = 0;
        for (int j = 0; j < NSUB; j++) begin
            c0[j] = s;
            rl[j] = s + D[j] - 1;
            s += D[j];
        end
        t_done = s + NR + 3;
        for (int j = 0; j < NSUB; j++) begin
            fdst[j*DSTW +: DSTW] = DSTW'(base + rl[j] + NR + 3);
            fcat[j*CATW +: CATW] = CATW'(cat_off + rl[j] + NR + 3);
        end
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
        for (int c = 0; c <= t_done + 1; c++) begin
            item_t it;
            it.re = '0; it.le = '0; it.oe = '0; it.pos = '0;
            for (int j = 0; j < NSUB; j++) begin
                if (c >= c0[j] && c <= rl[j]) begin
                    it.re[j] = 1'b1;
                    it.pos = DW'(c - c0[j]);
                end
                if (c - 1 >= c0[j] && c - 1 <= rl[j]) it.le[j] = 1'b1;
                if (c >= rl[j] + 2 && c <= rl[j] + NR + 2) it.oe[j] = 1'b1;
            end
            it.done = (c == t_done);
            it.chk_res = (c >= t_done);
            it.rdst = fdst;
            it.rcat = fcat;
            it.cyc = c;
            exp_q.push_back(it);
        end
        for (int c = 0; c <= t_done + 1; c++) begin
            bus_dst = DSTW'(base + c);
            bus_cat = CATW'(cat_off + c);
            start = (c == extra_start);
            @(posedge clk);
            #1;
        end
        start = 1'b0;
        while (exp_q.size() != 0) @(posedge clk);
        #1;
    endtask

    // Monitor: pops one expected item per cycle and compares at the falling edge.
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            item_t it;
            it = exp_q.pop_front();
            chk("R1 re", it.cyc, 64'(re), 64'(it.re));
            if (it.re != '0) chk("R1 rd_pos", it.cyc, 64'(rd_pos), 64'(it.pos));
            chk("R2 le", it.cyc, 64'(le), 64'(it.le));
            chk("R3 oe", it.cyc, 64'(oe), 64'(it.oe));
            chk("R5 done", it.cyc, 64'(done), 64'(it.done));
            if (it.chk_res) begin
                chk("R4 res_dst", it.cyc, 64'(res_dst), 64'(it.rdst));
                chk("R4 res_cat", it.cyc, 64'(res_cat), 64'(it.rcat));
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 enables in reset", 0, 64'({re, le, oe, done}), 64'(0));
        rst = 1'b0;
        @(negedge clk);
        chk("R7 enables after reset", 0, 64'({re, le, oe, done}), 64'(0));
        chk("R7 res_dst after reset", 0, 64'(res_dst), 64'(0));
        chk("R7 res_cat after reset", 0, 64'(res_cat), 64'(0));
        run_seq(100, 3, -1);
        run_seq(1500, 9, -1);
        // R6: a second start in the middle of a run changes nothing
        run_seq(2700, 5, 8);
        // R6: start during the final settle window
        run_seq(40, 12, 14);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1'b1;
            errors++;
            vectors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule